// File: doc/BRIEF.md
# Two-Phase Transfer Receive Sequencer

The block sits on the receiving side of a block transfer. The transfer is driven by a request line and answered on a single acknowledge line. When a request arrives and no transfer is pending, the sequencer prepares to take in two parameter words and signals readiness with an acknowledge pulse. The first parameter word is the destination address and the second is the word count. Once it holds both, it loads its address and word counters and pulses the same acknowledge line again. It then writes each incoming data word to a memory write port at consecutive addresses. After the last word it raises done and returns to idle. A request that arrives while a transfer is still in progress is refused and flagged on an error output.

Words enter through a valid/ready stream, normally fed by a word packer. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. The source must keep `in_data` stable while `in_valid` is high and `in_ready` is low. The sequencer pulls `in_ready` low whenever it cannot use a word: when idle and while an acknowledge pulse is running. The memory write port has no back-pressure. It is a registered strobe with an address and data that the memory must accept in the same cycle.

Top module: `xfer_rx_seq`

## Requirements
- R1: After reset, `ack_o`, `done_o`, `err_o`, `wr_en_o` and `in_ready` are all low.
- R2: When `req_i` goes from 0 to 1 while idle, the sequencer drives exactly one acknowledge pulse. The pulse stays high for ACK_CYCLES consecutive clocks (default 2) and is low before and after.
- R3: When `req_i` goes from 0 to 1 while a transfer is pending, `err_o` pulses high for one clock. The running transfer continues unchanged and no extra acknowledge is produced.
- R4: Only a 0-to-1 transition of `req_i` counts as a request. Holding `req_i` high does not start another transfer after the current one ends.
- R5: The first word accepted after the first acknowledge is the destination address, taken from its low AW bits. The second word is the word count, taken from its low CW bits. After the second word, a second acknowledge pulse of the same form appears on `ack_o`.
- R6: In the data phase, the k-th accepted word (k from 0) is written with `wr_en_o` high, `wr_addr_o` equal to the address plus k, and `wr_data_o` equal to the word. There is exactly one write per accepted word.
- R7: `in_ready` is low while idle and while `ack_o` is high. A word offered during that time is not consumed; it is taken once the sequencer is ready.
- R8: `done_o` pulses for one clock in the same cycle as the write of the last word. The sequencer is then idle and accepts a new request.
- R9: With a word count of zero, `done_o` pulses at the end of the second acknowledge, no write occurs, and the sequencer returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Transfer request; its rising edge is the request |
| in_valid | input | 1 | Stream word valid |
| in_data | input | 32 | Stream word |
| in_ready | output | 1 | Sequencer can take a word this cycle |
| ack_o | output | 1 | Acknowledge pulse for both phases |
| err_o | output | 1 | One-clock flag: request refused while busy |
| done_o | output | 1 | One-clock flag: transfer finished |
| wr_en_o | output | 1 | Memory write strobe |
| wr_addr_o | output | AW (16) | Memory write address |
| wr_data_o | output | 32 | Memory write data |

## Verification
On every cycle, the assertions check the following:
- `in_ready` stays low while acknowledging.
- Every write and every error flag follows an accepted word or a busy request in the previous cycle.
- The address steps by one per data word.
- Each acknowledge pulse starts right after its trigger.
- A request edge lasts only one clock.

Only the directed scenarios can show the end-to-end properties. These are the exact pulse width and the number of pulses, the order in which address and count are taken, and the written addresses and data. They also include the refusal of a mid-transfer request and the zero-count path. Finally, they show that a held-high request does not restart the sequencer.

// File: rtl/xfer_rx_pkg.sv
package xfer_rx_pkg;
  typedef enum logic [2:0] {
    S_IDLE     = 3'd0,
    S_ACK_CMD  = 3'd1,
    S_CMD_ADDR = 3'd2,
    S_CMD_CNT  = 3'd3,
    S_ACK_DATA = 3'd4,
    S_DATA     = 3'd5
  } seq_state_t;
endpackage

// File: rtl/xr_req_edge.sv
module xr_req_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic rise_o
);
  logic req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_i;
  end

  assign rise_o = req_i & ~req_q;

  // R2 / R4: a held request yields a single-cycle edge
  a_r4_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/xr_ack_gen.sv
module xr_ack_gen #(
  parameter int ACK_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic ack_o,
  output logic fin_o
);
  localparam int TW = $clog2(ACK_CYCLES + 1);
  localparam logic [TW-1:0] LOAD = TW'(ACK_CYCLES);

  logic [TW-1:0] tmr;

  always_ff @(posedge clk) begin
    if (!rst_n)            tmr <= '0;
    else if (start_i)      tmr <= LOAD;
    else if (tmr != '0)    tmr <= tmr - 1'b1;
  end

  assign ack_o = (tmr != '0);
  assign fin_o = (tmr == TW'(1));

  // R2: the pulse begins the cycle after its trigger
  a_r2_ack_starts: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> ack_o);
endmodule

// File: rtl/xr_xfer_cnt.sv
module xr_xfer_cnt #(
  parameter int DW = 32,
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_addr_i,
  input  logic          ld_cnt_i,
  input  logic          step_i,
  input  logic [DW-1:0] word_i,
  output logic [AW-1:0] addr_o,
  output logic          zero_o,
  output logic          last_o
);
  logic [AW-1:0] addr_hold;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_hold <= '0;
      addr_o    <= '0;
      cnt       <= '0;
    end else begin
      if (ld_addr_i) addr_hold <= word_i[AW-1:0];
      if (ld_cnt_i) begin
        addr_o <= addr_hold;
        cnt    <= word_i[CW-1:0];
      end else if (step_i) begin
        addr_o <= addr_o + 1'b1;
        cnt    <= cnt - 1'b1;
      end
    end
  end

  assign zero_o = (cnt == '0);
  assign last_o = (cnt == CW'(1));

  // R6: each data word moves the address on by one
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !ld_cnt_i) |=> addr_o == $past(addr_o) + 1'b1);
endmodule

// File: rtl/xfer_rx_seq.sv
module xfer_rx_seq #(
  parameter int DW         = 32,
  parameter int AW         = 16,
  parameter int CW         = 16,
  parameter int ACK_CYCLES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          ack_o,
  output logic          err_o,
  output logic          done_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  import xfer_rx_pkg::*;

  seq_state_t    st;
  logic          rise, acc, start_ack, ack_fin;
  logic          cnt_zero, cnt_last;
  logic [AW-1:0] cur_addr;

  xr_req_edge u_edge (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .rise_o(rise)
  );

  xr_ack_gen #(.ACK_CYCLES(ACK_CYCLES)) u_ack (
    .clk(clk), .rst_n(rst_n), .start_i(start_ack), .ack_o(ack_o), .fin_o(ack_fin)
  );

  xr_xfer_cnt #(.DW(DW), .AW(AW), .CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .ld_addr_i(st == S_CMD_ADDR && acc),
    .ld_cnt_i (st == S_CMD_CNT  && acc),
    .step_i   (st == S_DATA     && acc),
    .word_i(in_data), .addr_o(cur_addr), .zero_o(cnt_zero), .last_o(cnt_last)
  );

  assign in_ready  = (st == S_CMD_ADDR) || (st == S_CMD_CNT) || (st == S_DATA);
  assign acc       = in_valid && in_ready;
  assign start_ack = (st == S_IDLE && rise) || (st == S_CMD_CNT && acc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      err_o     <= 1'b0;
      done_o    <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      err_o   <= rise && (st != S_IDLE);
      done_o  <= 1'b0;
      wr_en_o <= 1'b0;
      unique case (st)
        S_IDLE:     if (rise) st <= S_ACK_CMD;
        S_ACK_CMD:  if (ack_fin) st <= S_CMD_ADDR;
        S_CMD_ADDR: if (acc) st <= S_CMD_CNT;
        S_CMD_CNT:  if (acc) st <= S_ACK_DATA;
        S_ACK_DATA: if (ack_fin) begin
          if (cnt_zero) begin
            st     <= S_IDLE;
            done_o <= 1'b1;
          end else begin
            st <= S_DATA;
          end
        end
        S_DATA: if (acc) begin
          wr_en_o   <= 1'b1;
          wr_addr_o <= cur_addr;
          wr_data_o <= in_data;
          if (cnt_last) begin
            st     <= S_IDLE;
            done_o <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R7: no word is taken while acknowledging
  a_r7_no_ready_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> !in_ready);
  // R3: an error flag follows a request edge seen while busy
  a_r3_err_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(rise && st != S_IDLE));
  // R6: every write comes from a word accepted the cycle before
  a_r6_wr_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> $past(in_valid && in_ready));
  // R8: done leaves the block idle, taking nothing
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !in_ready && !ack_o);
endmodule

// File: tb/sim_xfer_rx_seq.sv
`timescale 1ns/1ps
module sim_xfer_rx_seq;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_i = 1'b0;
  logic          in_valid = 1'b0;
  logic [31:0]   in_data = '0;
  logic          in_ready, ack_o, err_o, done_o, wr_en_o;
  logic [AW-1:0] wr_addr_o;
  logic [31:0]   wr_data_o;

  always #2.5 clk = ~clk;

  xfer_rx_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .ack_o(ack_o), .err_o(err_o), .done_o(done_o),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  int checks = 0, errors = 0;
  int ack_run = 0, ack_last = 0, ack_n = 0, ack_bad = 0;
  int ready_in_ack = 0, done_n = 0, done_nowr = 0, err_n = 0, wr_n = 0;
  logic [AW-1:0] addr_log [0:63];
  logic [31:0]   data_log [0:63];

  always @(negedge clk) begin
    if (ack_o) ack_run++;
    else if (ack_run != 0) begin
      ack_last = ack_run;
      if (ack_run != 2) ack_bad++;
      ack_n++;
      ack_run = 0;
    end
    if (ack_o && in_ready) ready_in_ack++;
    if (wr_en_o && wr_n < 64) begin
      addr_log[wr_n] = wr_addr_o;
      data_log[wr_n] = wr_data_o;
      wr_n++;
    end
    if (done_o) begin
      done_n++;
      if (!wr_en_o) done_nowr++;
    end
    if (err_o) err_n++;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_req();
    @(negedge clk); req_i = 1'b1;
    @(negedge clk); req_i = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] w, input int gap);
    repeat (gap) @(negedge clk);
    @(negedge clk); in_valid = 1'b1; in_data = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic wait_ack(input int target);
    while (ack_n < target) @(negedge clk);
  endtask

  task automatic wait_done(input int target);
    while (done_n < target) @(negedge clk);
    @(negedge clk);
  endtask

  // runs a transfer; early=1 offers words without waiting for acknowledges
  task automatic run_xfer(input logic [AW-1:0] base, input int n, input int gap,
                          input bit early, input bit poke);
    int a0 = ack_n;
    int d0 = done_n;
    wr_n = 0;
    pulse_req();
    if (!early) wait_ack(a0 + 1);
    send_word({16'hA5A5, base}, gap);
    if (poke) pulse_req();
    send_word({16'h5A00, 16'(n)}, gap);
    if (!early) wait_ack(a0 + 2);
    for (int k = 0; k < n; k++) send_word(32'hC0DE_0000 + 32'(k * 3 + base), gap);
    wait_done(d0 + 1);
  endtask

  task automatic check_writes(input logic [AW-1:0] base, input int n, input string tag);
    check(wr_n == n, {tag, " write count"}, wr_n, n);
    for (int k = 0; k < n && k < 64; k++) begin
      check(addr_log[k] == base + AW'(k), {tag, " write addr"}, addr_log[k], base + AW'(k));
      check(data_log[k] == 32'hC0DE_0000 + 32'(k * 3 + base), {tag, " write data"},
            data_log[k], 32'hC0DE_0000 + 32'(k * 3 + base));
    end
  endtask

  task automatic t_reset();
    check({ack_o, done_o, err_o, wr_en_o, in_ready} == 5'b0, "R1 outputs after reset",
          {ack_o, done_o, err_o, wr_en_o, in_ready}, 0);
  endtask

  task automatic t_basic();
    int a0 = ack_n;
    run_xfer(16'h0100, 4, 0, 1'b0, 1'b0);
    check(ack_n - a0 == 2, "R5 two acknowledges", ack_n - a0, 2);
    check(ack_last == 2, "R2 ack width", ack_last, 2);
    check_writes(16'h0100, 4, "R6");
    check(done_nowr == 0, "R8 done with last write", done_nowr, 0);
    check(!in_ready, "R8 idle after done", in_ready, 0);
  endtask

  task automatic t_backpressure();
    int r0 = ready_in_ack;
    run_xfer(16'h2200, 3, 2, 1'b1, 1'b0);
    check(ready_in_ack == r0, "R7 ready low during ack", ready_in_ack - r0, 0);
    check_writes(16'h2200, 3, "R7");
  endtask

  task automatic t_reject();
    int e0 = err_n;
    int a0 = ack_n;
    run_xfer(16'h0040, 2, 0, 1'b0, 1'b1);
    check(err_n - e0 == 1, "R3 error on busy request", err_n - e0, 1);
    check(ack_n - a0 == 2, "R3 no extra ack", ack_n - a0, 2);
    check_writes(16'h0040, 2, "R3");
  endtask

  task automatic t_zero();
    int z0 = done_nowr;
    run_xfer(16'h0777, 0, 0, 1'b0, 1'b0);
    check(wr_n == 0, "R9 no write on zero count", wr_n, 0);
    check(done_nowr - z0 == 1, "R9 done without write", done_nowr - z0, 1);
  endtask

  task automatic t_level();
    int a0;
    @(negedge clk); req_i = 1'b1;
    wait_ack(ack_n + 1);
    send_word(32'h0000_0300, 0);
    send_word(32'h0000_0001, 0);
    send_word(32'hC0DE_0300, 0);
    wait_done(done_n + 1);
    a0 = ack_n;
    repeat (20) @(negedge clk);
    check(ack_n == a0 && !ack_o, "R4 held request ignored", ack_n - a0, 0);
    @(negedge clk); req_i = 1'b0;
    pulse_req();
    repeat (ACKW + 2) @(negedge clk);
    check(ack_n == a0 + 1, "R8 new request accepted", ack_n - a0, 1);
    send_word(32'h0, 0);
    send_word(32'h0, 0);
    wait_done(done_n + 1);
  endtask
  localparam int ACKW = 2;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_backpressure();
    t_reject();
    t_zero();
    t_level();
    check(ack_bad == 0, "R2 every ack width", ack_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule